// File: doc/BRIEF.md
# Receive FIFO with Error-Tagged Line-Status Interrupt

This block buffers received characters for a serial port. Every character enters with three error flags: parity, framing and break. Each stored entry keeps its flags next to its data, so the entry at the head of the queue shows its own flags to the host while the host reads it. A line-status interrupt is built from these flags. A mode input picks when the interrupt fires, and there are two choices.

In deferred mode (`mode_immediate` = 0, the reset default), the interrupt is high only while a flagged character sits at the head of the queue, ready to be read. In immediate mode, the interrupt fires on the clock edge that stores a flagged character. It then stays latched until the host acknowledges the status word, even if clean characters follow or the flagged character is read out. A write that finds the queue full is dropped and sets a sticky overrun bit. The overrun bit never raises the interrupt.

Top module: `rx_err_fifo`

## Requirements
- R1: While `rst_n` is low and after reset, `level` is 0, `rd_valid` is 0, `lsr_int` is 0 and `lsr_status` is 0. Deferred mode applies whenever `mode_immediate` is 0.
- R2: The queue holds up to DEPTH (64) characters in first-in first-out order. `level` rises by 1 on the edge of an accepted write and falls by 1 on the edge of a read. A write and a read in the same cycle leave it unchanged. `level` never exceeds DEPTH.
- R3: A write while the queue is full, with no read in the same cycle, is dropped and leaves the contents unchanged. It sets `lsr_status[1]` (overrun), which stays set until `lsr_ack`. The overrun bit never raises `lsr_int`. A write is accepted when the queue is full if a read happens in the same cycle.
- R4: While `rd_valid` is 1, `rd_data` and `rd_err` show the head entry's data and flags. The flag encoding is bit 0 parity, bit 1 framing and bit 2 break, the same as `wr_err`. While the queue is empty, both are 0.
- R5: In deferred mode, `lsr_status[4:2]` equals the head entry's flags. `lsr_int` is 1 exactly when the queue is not empty and the head entry has a nonzero flag.
- R6: In immediate mode, an accepted write with a nonzero `wr_err` ORs its flags into a latched set. From the next cycle on, `lsr_status[4:2]` shows the latched set and `lsr_int` is 1. This holds through later clean writes and reads, until `lsr_ack`. Flags are latched only while `mode_immediate` is 1.
- R7: `lsr_ack` clears the latched flags and the overrun bit on the next edge. A flagged write accepted in the same cycle wins over the clear.
- R8: A read while the queue is empty is ignored: `level` stays 0 and the outputs do not change.
- R9: `lsr_status[0]` equals `rd_valid`, which is 1 exactly when `level` is not zero. `lsr_status[7:5]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_immediate | input | 1 | 1: interrupt on entry; 0: interrupt at the head of the queue |
| wr_en | input | 1 | Store one character |
| wr_data | input | DATA_W | Character to store |
| wr_err | input | 3 | Flags of the character (0 parity, 1 framing, 2 break) |
| rd_en | input | 1 | Remove the head character |
| lsr_ack | input | 1 | Host read of the status word; clears latched flags and overrun |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | DATA_W | Head character |
| rd_err | output | 3 | Flags of the head character |
| level | output | $clog2(DEPTH+1) | Number of stored characters |
| lsr_status | output | 8 | Status word: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break |
| lsr_int | output | 1 | Line-status interrupt |

## Verification
Every result is registered, so a write, read or acknowledge shows on `level`, the head outputs, the latched flags and `lsr_int` one edge later. `mode_immediate` is the one exception. It only selects between registered values, so switching it changes `lsr_status[4:2]` and `lsr_int` in the same cycle. The bench changes inputs just after a rising edge and advances its queue-based model on that edge. It compares every output at the following falling edge, the point where both the one-edge results and the same-cycle mode selection have settled.

// File: rtl/rx_err_fifo_pkg.sv
`timescale 1ns/1ps
package rx_err_fifo_pkg;
   localparam int ERR_W = 3;
   localparam int ST_READY = 0;
   localparam int ST_OVR   = 1;
   localparam int ST_ERR_L = 2;

   typedef logic [ERR_W-1:0] err_t;

   function automatic logic [7:0] pack_status(input logic ready, input logic ovr, input err_t err);
      logic [7:0] s;
      s = 8'h00;
      s[ST_READY] = ready;
      s[ST_OVR] = ovr;
      s[ST_ERR_L +: ERR_W] = err;
      return s;
   endfunction
endpackage

// File: rtl/rxf_store.sv
`timescale 1ns/1ps
module rxf_store
   import rx_err_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   input  err_t                       wr_err,
   input  logic                       rd_en,
   output logic                       push_ok,
   output logic                       push_drop,
   output logic                       head_valid,
   output logic [DATA_W-1:0]          head_data,
   output err_t                       head_err,
   output logic [$clog2(DEPTH+1)-1:0] fill
);
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W  = $clog2(DEPTH+1);
   localparam int ENT_W  = DATA_W + ERR_W;
   localparam bit POW2   = (DEPTH == (1 << PTR_W));

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             full, pop_ok;

   assign full      = (cnt == CNT_W'(DEPTH));
   assign pop_ok    = rd_en && (cnt != '0);
   assign push_ok   = wr_en && (!full || pop_ok);
   assign push_drop = wr_en && !push_ok;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= {wr_err, wr_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   logic [ENT_W-1:0] head_raw;
   assign head_raw   = mem[rd_ptr];
   assign head_valid = (cnt != '0);
   assign head_data  = head_valid ? head_raw[DATA_W-1:0] : '0;
   assign head_err   = head_valid ? head_raw[ENT_W-1:DATA_W] : '0;
   assign fill       = cnt;
endmodule

// File: rtl/rxf_err_track.sv
`timescale 1ns/1ps
module rxf_err_track
   import rx_err_fifo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_immediate,
   input  logic       push_ok,
   input  logic       push_drop,
   input  err_t       push_err,
   input  logic       ack,
   input  logic       head_valid,
   input  err_t       head_err,
   output logic [7:0] status,
   output logic       irq
);
   err_t latched;
   logic ovr;
   err_t shown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= '0;
         ovr     <= 1'b0;
      end else begin
         latched <= (ack ? '0 : latched) |
                    ((push_ok && mode_immediate) ? push_err : '0);
         ovr     <= push_drop | (ovr & ~ack);
      end
   end

   assign shown  = mode_immediate ? latched : head_err;
   assign status = pack_status(head_valid, ovr, shown);
   assign irq    = |status[ST_ERR_L +: ERR_W];
endmodule

// File: rtl/rx_err_fifo.sv
`timescale 1ns/1ps
module rx_err_fifo
   import rx_err_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_immediate,
   input  logic                       wr_en,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [2:0]                 wr_err,
   input  logic                       rd_en,
   input  logic                       lsr_ack,
   output logic                       rd_valid,
   output logic [DATA_W-1:0]          rd_data,
   output logic [2:0]                 rd_err,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic [7:0]                 lsr_status,
   output logic                       lsr_int
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_err_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("rx_err_fifo: DATA_W must be 1..32");
      end
   endgenerate

   logic push_ok, push_drop;
   err_t head_err;

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .wr_err     (wr_err),
      .rd_en      (rd_en),
      .push_ok    (push_ok),
      .push_drop  (push_drop),
      .head_valid (rd_valid),
      .head_data  (rd_data),
      .head_err   (head_err),
      .fill       (level)
   );

   rxf_err_track u_track (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_immediate (mode_immediate),
      .push_ok        (push_ok),
      .push_drop      (push_drop),
      .push_err       (wr_err),
      .ack            (lsr_ack),
      .head_valid     (rd_valid),
      .head_err       (head_err),
      .status         (lsr_status),
      .irq            (lsr_int)
   );

   assign rd_err = head_err;
endmodule

// File: rtl/rx_err_fifo_chk.sv
`timescale 1ns/1ps
module rx_err_fifo_chk #(
   parameter int DEPTH = 64
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mode_immediate,
   input logic                       wr_en,
   input logic [2:0]                 wr_err,
   input logic                       rd_en,
   input logic                       rd_valid,
   input logic [2:0]                 rd_err,
   input logic [$clog2(DEPTH+1)-1:0] level,
   input logic [7:0]                 lsr_status,
   input logic                       lsr_int
);
   localparam int CW = $clog2(DEPTH+1);

   p_level_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && level < CW'(DEPTH)) |=> level == $past(level) + 1'b1);

   p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && level == CW'(DEPTH)) |=> lsr_status[1]);

   p_deferred_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_immediate && lsr_int) |-> (rd_valid && rd_err != 3'b000));

   p_immediate_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_immediate && wr_en && wr_err != 3'b000 && (level < CW'(DEPTH) || rd_en))
      |=> (lsr_int || !mode_immediate));

   p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && level == '0) |=> level == '0);

   p_ready_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_status[0] == rd_valid) && (lsr_status[7:5] == 3'b000));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_immediate (mode_immediate),
   .wr_en          (wr_en),
   .wr_err         (wr_err),
   .rd_en          (rd_en),
   .rd_valid       (rd_valid),
   .rd_err         (rd_err),
   .level          (level),
   .lsr_status     (lsr_status),
   .lsr_int        (lsr_int)
);

// File: tb/rx_err_fifo_test.sv
`timescale 1ns/1ps
module rx_err_fifo_test;
   localparam int DW = 8;
   localparam int DEPTH = 64;
   localparam int CW = $clog2(DEPTH+1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_immediate = 1'b0;
   logic wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0] wr_err = '0;
   logic rd_en = 1'b0;
   logic lsr_ack = 1'b0;
   logic rd_valid;
   logic [DW-1:0] rd_data;
   logic [2:0] rd_err;
   logic [CW-1:0] level;
   logic [7:0] lsr_status;
   logic lsr_int;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rx_err_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .mode_immediate(mode_immediate),
      .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err), .rd_en(rd_en),
      .lsr_ack(lsr_ack), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_err(rd_err), .level(level), .lsr_status(lsr_status), .lsr_int(lsr_int)
   );

   // behavioural model: each entry is {err, data}
   logic [10:0] q[$];
   logic [2:0] m_latch = '0;
   logic m_ovr = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         q = {};
         m_latch = '0;
         m_ovr = 1'b0;
      end else begin
         bit pop, push;
         pop  = rd_en && (q.size() > 0);
         push = wr_en && ((q.size() < DEPTH) || pop);
         if (pop) void'(q.pop_front());
         if (push) q.push_back({wr_err, wr_data});
         if (lsr_ack) begin m_latch = '0; m_ovr = 1'b0; end
         if (push && mode_immediate) m_latch = m_latch | wr_err;
         if (wr_en && !push) m_ovr = 1'b1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         logic [2:0] h_err, shown;
         logic [7:0] h_dat, st;
         h_err = (q.size() > 0) ? q[0][10:8] : 3'b0;
         h_dat = (q.size() > 0) ? q[0][7:0] : 8'h0;
         shown = mode_immediate ? m_latch : h_err;
         st = {3'b000, shown, m_ovr, q.size() > 0};
         check(level == CW'(q.size()), "R2 level", level, q.size());
         check(rd_valid == (q.size() > 0), "R9 rd_valid", rd_valid, q.size() > 0);
         check(rd_data == h_dat && rd_err == h_err, "R4 head", {rd_err, rd_data}, {h_err, h_dat});
         check(lsr_status[1] == m_ovr, "R3 overrun", lsr_status[1], m_ovr);
         check(lsr_status == st, mode_immediate ? "R6 status" : "R5 status", lsr_status, st);
         check(lsr_int == (|shown), mode_immediate ? "R6 int" : "R5 int", lsr_int, |shown);
      end
   end

   task automatic step(input bit we, input logic [7:0] d, input logic [2:0] e,
                       input bit re, input bit ack);
      @(posedge clk); #1;
      wr_en = we; wr_data = d; wr_err = e; rd_en = re; lsr_ack = ack;
   endtask

   task automatic idle();
      step(0, 8'h00, 3'b000, 0, 0);
   endtask

   initial begin
      #(200000 * 20);
      checks++; errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(level == 0 && lsr_status == 8'h00 && !lsr_int, "R1 reset", lsr_status, 0);
      rst_n = 1'b1;
      // R5 deferred: clean, errored, clean
      step(1, 8'h11, 3'b000, 0, 0);
      step(1, 8'h22, 3'b010, 0, 0);
      step(1, 8'h33, 3'b000, 0, 0);
      idle();
      @(negedge clk);
      check(!lsr_int, "R5 clean head no int", lsr_int, 0);
      step(0, 8'h00, 3'b000, 1, 0);
      idle();
      @(negedge clk);
      check(lsr_int && lsr_status[3], "R5 errored at head", lsr_status, 8'h09);
      step(0, 8'h00, 3'b000, 1, 0);
      step(0, 8'h00, 3'b000, 1, 0);
      idle();
      // R8 read while empty
      step(0, 8'h00, 3'b000, 1, 0);
      idle();
      @(negedge clk);
      check(level == 0 && !rd_valid, "R8 empty read", level, 0);
      // R6 immediate mode
      mode_immediate = 1'b1;
      step(1, 8'h44, 3'b100, 0, 0);
      step(1, 8'h55, 3'b000, 0, 0);
      step(0, 8'h00, 3'b000, 1, 0);
      step(0, 8'h00, 3'b000, 1, 0);
      idle();
      @(negedge clk);
      check(lsr_int && lsr_status[4], "R6 latched after drain", lsr_status, 8'h10);
      // R7 ack with simultaneous flagged write
      step(1, 8'h66, 3'b001, 0, 1);
      idle();
      @(negedge clk);
      check(lsr_int && lsr_status[4:2] == 3'b001, "R7 set wins", lsr_status[4:2], 1);
      step(0, 8'h00, 3'b000, 0, 1);
      idle();
      @(negedge clk);
      check(!lsr_int, "R7 ack clears", lsr_int, 0);
      step(0, 8'h00, 3'b000, 1, 0);
      // R3 fill past full
      mode_immediate = 1'b0;
      for (int i = 0; i < DEPTH + 3; i++) step(1, 8'(i), 3'b000, 0, 0);
      step(1, 8'hAA, 3'b000, 1, 0);
      idle();
      @(negedge clk);
      check(level == CW'(DEPTH) && lsr_status[1] && !lsr_int, "R3 full overrun", level, DEPTH);
      for (int i = 0; i < DEPTH + 2; i++) step(0, 8'h00, 3'b000, 1, i == 0);
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 99) < 3) mode_immediate = ~mode_immediate;
         step($urandom_range(0, 99) < 55, 8'($urandom),
              ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
              $urandom_range(0, 99) < 45, $urandom_range(0, 99) < 8);
      end
      idle();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule